// File: doc/BRIEF.md
# Two-Wire Register Write Slave

This block is a slave on a two-wire serial bus (I2C-style) that turns bus write transactions into writes on a synchronous register-file port. It samples the clock and data lines on its own system clock and decodes start and stop conditions from them. After a start it takes a byte holding a 7-bit device address and a direction bit. It then takes a 16-bit register pointer in two bytes, and after that any number of data bytes.

Each data byte produces a single-cycle write strobe carrying the current pointer and the byte. The pointer then steps to the next address, so a burst fills consecutive registers. The slave acknowledges every byte it accepts by pulling the data line low during the ninth clock. It goes quiet when the transfer is not addressed to it as a write. Reading, clock stretching and extended addressing are not part of this block.

Top module: `twowire_reg_writer`

## Requirements
- R1: After reset, sda_oe and wr_en are 0. The slave stays idle and treats bus clocks as noise until a start condition arrives.
- R2: A start condition is SDA falling while SCL is high. It begins a device-address byte. A start that arrives in the middle of a transaction (repeated start) discards any partial pointer and returns the parser to the device-address byte.
- R3: The first byte is sent MSB first: bits [7:1] are the device address and bit [0] is the direction. When [7:1] equals DEV_ADDR and [0] is 0, the byte is acknowledged. Otherwise it is not acknowledged, and the slave drives nothing and writes nothing until the next start or stop.
- R4: The next two bytes form the register pointer, bits [15:8] first and then bits [7:0]. Each of these bytes is acknowledged.
- R5: The first data byte is written to the pointer value M. wr_en rises within a few system clocks of the SCL rising edge that carries the eighth data bit.
- R6: Each later data byte in the same transaction is written to the next address, so L bytes land at M to M+L-1. Every data byte is acknowledged.
- R7: The pointer increments modulo 2^16, so the byte after the one written at 0xFFFF goes to 0x0000.
- R8: A stop condition is SDA rising while SCL is high. It releases SDA and ends the transaction. Bytes clocked after a stop, with no new start, are neither acknowledged nor written.
- R9: An acknowledge is a low level on SDA for the ninth SCL period. sda_oe changes only while SCL is low, except when a start or stop releases it.
- R10: wr_en is high for exactly one system-clock cycle per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, pull the data line low |
| wr_en | output | 1 | Register-file write strobe, one cycle |
| wr_addr | output | 16 | Register-file write address |
| wr_data | output | 8 | Register-file write data |

## Verification
Two things happen in the same system-clock cycle: the write strobe for the register at 0xFFFF, and the pointer step that wraps it to 0x0000. The bench provokes this with a three-byte burst that starts at 0xFFFE. It judges the result by the addresses of the strobes that come out: 0xFFFE, 0xFFFF and then 0x0000, each paired with its own data byte. If the wrap misbehaves, the third write shows up at the wrong address or carries the wrong data.

// File: rtl/twowire_reg_writer.sv
module twowire_reg_writer #(
  parameter logic [6:0] DEV_ADDR = 7'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic        wr_en,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data
);
  typedef enum logic [2:0] {P_IDLE, P_DEV, P_RHI, P_RLO, P_DATA, P_SKIP} phase_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  phase_t     phase;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [1:0] ack;
  logic [15:0] ptr;
  logic [7:0] byte_in;

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];

  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire rx_phase = (phase == P_DEV) || (phase == P_RHI) || (phase == P_RLO) || (phase == P_DATA);

  assign byte_in = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ack     <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start) begin
        phase  <= P_DEV;
        cnt    <= '0;
        ack    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        phase  <= P_IDLE;
        cnt    <= '0;
        ack    <= '0;
        sda_oe <= 1'b0;
      end else if (ack == 2'd1 && scl_fall) begin
        sda_oe <= 1'b1;
        ack    <= 2'd2;
      end else if (ack == 2'd2 && scl_fall) begin
        sda_oe <= 1'b0;
        ack    <= 2'd0;
      end else if (ack == 2'd0 && scl_rise && rx_phase) begin
        sh  <= byte_in;
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          ack <= 2'd1;
          case (phase)
            P_DEV: begin
              if (byte_in[7:1] == DEV_ADDR && !byte_in[0]) phase <= P_RHI;
              else begin
                phase <= P_SKIP;
                ack   <= 2'd0;
              end
            end
            P_RHI: begin
              ptr[15:8] <= byte_in;
              phase     <= P_RLO;
            end
            P_RLO: begin
              ptr[7:0] <= byte_in;
              phase    <= P_DATA;
            end
            default: begin
              wr_en   <= 1'b1;
              wr_addr <= ptr;
              wr_data <= byte_in;
              ptr     <= ptr + 16'd1;
            end
          endcase
        end
      end
    end
  end

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_strobe_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_rise));
  assert_quiet_when_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SKIP || phase == P_IDLE) |-> !sda_oe);
  assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && phase == P_IDLE));
  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == P_DEV && cnt == 3'd0));
  assert_pointer_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'hFFFF) |-> ptr == 16'h0000);
endmodule

// File: tb/twowire_reg_writer_tb_top.sv
module twowire_reg_writer_tb_top;
  localparam logic [6:0] DEV = 7'h3C;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  logic prev_wr = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twowire_reg_writer #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    got = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
    check(got == exp_ack, req, got, exp_ack);
  endtask

  task automatic expect_wr(input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic drain(input string req);
    tick(20);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        logic [23:0] e;
        check(!prev_wr, "R10 strobe width", 1, 0);
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R5/R6 write", {wr_addr, wr_data}, e);
        end
      end
      prev_wr <= wr_en;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    check(sda_oe == 1'b0 && wr_en == 1'b0, "R1 reset outputs", {sda_oe, wr_en}, 0);
    rst_n = 1'b1; tick(5);
    // R1: clocks with no start give no ack
    send_byte({DEV, 1'b0}, 1'b0, "R1 idle ignores bus");
    drain("R1 no write");

    // single write R4 R5
    expect_wr(16'h1234, 8'hA5);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R3 addr ack");
    send_byte(8'h12, 1'b1, "R4 pointer high ack");
    send_byte(8'h34, 1'b1, "R4 pointer low ack");
    send_byte(8'hA5, 1'b1, "R5 data ack");
    bus_stop();
    drain("R5 single write");

    // burst R6
    for (int i = 0; i < 4; i++) expect_wr(16'h00F0 + 16'(i), 8'h10 + 8'(i));
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R3 addr ack");
    send_byte(8'h00, 1'b1, "R4 hi");
    send_byte(8'hF0, 1'b1, "R4 lo");
    for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i), 1'b1, "R6 burst ack");
    bus_stop();
    drain("R6 burst");

    // wrong address R3
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, "R3 mismatch nack");
    send_byte(8'h00, 1'b0, "R3 ignored byte");
    send_byte(8'h55, 1'b0, "R3 ignored byte");
    bus_stop();
    drain("R3 mismatch no write");

    // read direction R3
    bus_start();
    send_byte({DEV, 1'b1}, 1'b0, "R3 read nack");
    send_byte(8'h77, 1'b0, "R3 ignored after read");
    bus_stop();
    drain("R3 read no write");

    // wrap R7
    expect_wr(16'hFFFE, 8'h01);
    expect_wr(16'hFFFF, 8'h02);
    expect_wr(16'h0000, 8'h03);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R3 addr ack");
    send_byte(8'hFF, 1'b1, "R4 hi");
    send_byte(8'hFE, 1'b1, "R4 lo");
    send_byte(8'h01, 1'b1, "R7 data");
    send_byte(8'h02, 1'b1, "R7 data");
    send_byte(8'h03, 1'b1, "R7 wrap data");
    bus_stop();
    drain("R7 wrap");

    // repeated start mid pointer and mid data R2
    expect_wr(16'h0100, 8'hC1);
    expect_wr(16'h0200, 8'hC2);
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R3 addr ack");
    send_byte(8'h09, 1'b1, "R4 hi partial");
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 restart addr ack");
    send_byte(8'h01, 1'b1, "R4 hi");
    send_byte(8'h00, 1'b1, "R4 lo");
    send_byte(8'hC1, 1'b1, "R2 data");
    bus_start();
    send_byte({DEV, 1'b0}, 1'b1, "R2 restart addr ack");
    send_byte(8'h02, 1'b1, "R4 hi");
    send_byte(8'h00, 1'b1, "R4 lo");
    send_byte(8'hC2, 1'b1, "R2 data after restart");
    bus_stop();
    drain("R2 repeated start");

    // after stop R8
    send_byte(8'h5A, 1'b0, "R8 after stop nack");
    send_byte(8'hA5, 1'b0, "R8 after stop nack");
    drain("R8 no write after stop");
    check(sda_oe == 1'b0, "R9 released", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule